// File: doc/BRIEF.md
# Packet DMA Command and Interrupt Cause Unit

This block is the processor-side control state for a packet DMA engine. It keeps the receive-enable bit and the two abort commands (receive and transmit) that the DMA engines act on. An abort command stays set until the engine it addresses reports that it is idle. Software therefore learns that an abort has finished by reading the command word until the abort bit reads back as zero.

The unit also collects event pulses from the engines into a sticky cause register and gates it through a mask register. Bit 31 of the cause word is a live summary: the OR of the unmasked cause bits 30 down to 4. The interrupt line is that summary, registered. Receive buffer-return causes are qualified by the enable-interrupt flag of the closed descriptor. When frame-boundary mode is selected, they are also qualified by the descriptor being the last of its frame.

Registers are reached through a two-bit word address with single-cycle writes. The read port is combinational from the current register state.

Top module: `dma_cmd_unit`

## Requirements
- R1: After reset the command, cause and mask words read as zero, and `rxEnable`, `abortRx`, `abortTx` and `irqOut` are low.
- R2: Command word (address 0): writing 1 to bit 7 sets `rxEnable`, and writing 0 to bit 7 leaves it unchanged. Writing 1 to bit 15 clears `rxEnable`, and this wins over bit 7 in the same write.
- R3: Writing 1 to bit 15 (receive) or bit 31 (transmit) of the command word sets the matching abort output. The abort stays set while its idle input is low and clears one cycle after the idle input is seen high. Writing 0 to an abort bit has no effect. Bits 7, 15 and 31 read back the live state.
- R4: A receive resource-error pulse on queue q sets cause bit 20+q. A transmit underrun pulse sets cause bit 13. A management-interface completion pulse sets cause bit 29. Each becomes visible in the cycle after the pulse.
- R5: A descriptor close on queue q sets cause bit 16+q and cause bit 0 only when its enable-interrupt flag is 1 and, with `frameOnly` high, its last-in-frame flag is also 1.
- R6: Writing the cause word (address 1) clears each bit written as 0 and keeps each bit written as 1. An event arriving in the same cycle as a clear leaves its bit set.
- R7: The mask word (address 2) stores bits 0, 13, 29, 16 to 16+NUM_Q-1 and 20 to 20+NUM_Q-1. All its other bits read as zero.
- R8: Cause bit 31 reads as the OR of (cause AND mask) over bits 30 down to 4, so bit 0 never contributes.
- R9: `irqOut` equals the cause-word bit 31 value of the previous cycle.
- R10: Unimplemented cause and command bits read as zero and ignore writes, address 3 reads as zero, and writes cannot set cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 command, 1 cause, 2 mask, 3 none |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| rxIdle | input | 1 | Receive engine is idle |
| txIdle | input | 1 | Transmit engine is idle |
| rxEnable | output | 1 | Receive enable to the engine |
| abortRx | output | 1 | Receive abort request |
| abortTx | output | 1 | Transmit abort request |
| frameOnly | input | 1 | Buffer-return causes only on the last descriptor of a frame |
| descClose | input | NUM_Q | Per-queue receive descriptor closed |
| descIntEn | input | NUM_Q | Enable-interrupt flag of the closed descriptor |
| descLast | input | NUM_Q | Closed descriptor is the last of its frame |
| rxResErr | input | NUM_Q | Per-queue receive resource error pulse |
| txUnderrun | input | 1 | Transmit underrun pulse |
| smiDone | input | 1 | Management-interface operation complete pulse |
| irqOut | output | 1 | Registered interrupt summary |

## Verification
A cause bit stuck high or low shows in the cause readback on the cycle after the stimulus. If the bit is in the summary range, it also shows on `irqOut` one cycle later. A wrong abort state shows directly on the abort outputs, which must hold through a long non-idle wait and drop exactly one cycle after idle. The bench sweeps every implemented cause bit against a single-bit mask, and every combination of descriptor flags and frame mode on every queue. A summary range, qualification term or bit position that is off by one therefore shows as a readback mismatch.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  // command word bit positions
  localparam int unsigned BIT_RX_EN    = 7;
  localparam int unsigned BIT_ABORT_RX = 15;
  localparam int unsigned BIT_ABORT_TX = 31;

  // cause / mask bit positions
  localparam int unsigned BIT_ANY_RET  = 0;
  localparam int unsigned BIT_TX_UNDER = 13;
  localparam int unsigned BIT_SMI_DONE = 29;
  localparam int unsigned BIT_SUMMARY  = 31;
  localparam int unsigned RET_LSB      = 16;
  localparam int unsigned ERR_LSB      = 20;
  localparam int unsigned SUM_LO       = 4;
  localparam int unsigned SUM_HI       = 30;
  localparam int unsigned MAX_Q        = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD   = 2'd0,
    REG_CAUSE = 2'd1,
    REG_MASK  = 2'd2,
    REG_NONE  = 2'd3
  } regSel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic    wrCause;
    logic    wrMask;
    regSel_e rdSel;
  } ctrlStrobe_t;

  function automatic logic [DATA_W-1:0] implMask(int unsigned nq);
    logic [DATA_W-1:0] m;
    m = '0;
    m[BIT_ANY_RET]  = 1'b1;
    m[BIT_TX_UNDER] = 1'b1;
    m[BIT_SMI_DONE] = 1'b1;
    for (int unsigned q = 0; q < nq; q++) begin
      m[RET_LSB+q] = 1'b1;
      m[ERR_LSB+q] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
  import dma_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2:0]          cmdBits,   // {abort tx, abort rx, rx enable}
  input  logic                rxIdle,
  input  logic                txIdle,
  output ctrlStrobe_t         strobe,
  output logic                rxEnable,
  output logic                abortRx,
  output logic                abortTx,
  output logic [DATA_W-1:0]   cmdWord
);
  localparam int unsigned NUM_ABORT = 2;

  logic                 wrCmd;
  logic                 rxEnQ;
  logic [NUM_ABORT-1:0] abortQ;
  logic [NUM_ABORT-1:0] abortReq;
  logic [NUM_ABORT-1:0] idleIn;

  always_comb begin
    wrCmd          = wrEn && (addr == REG_CMD);
    strobe.wrCause = wrEn && (addr == REG_CAUSE);
    strobe.wrMask  = wrEn && (addr == REG_MASK);
    strobe.rdSel   = regSel_e'(addr);
  end

  assign abortReq = {wrCmd & cmdBits[2], wrCmd & cmdBits[1]};
  assign idleIn   = {txIdle, rxIdle};

  // one pending-abort flop per engine; cleared once the engine is idle
  for (genvar ch = 0; ch < NUM_ABORT; ch++) begin : g_abort
    logic pendQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ <= 1'b0;
      else       pendQ <= abortReq[ch] | (pendQ & ~idleIn[ch]);
    end
    assign abortQ[ch] = pendQ;
  end

  // receive enable: set by command, cleared by receive abort (abort wins)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rxEnQ <= 1'b0;
    else if (abortReq[0])       rxEnQ <= 1'b0;
    else if (wrCmd & cmdBits[0]) rxEnQ <= 1'b1;
  end

  assign rxEnable = rxEnQ;
  assign abortRx  = abortQ[0];
  assign abortTx  = abortQ[1];

  always_comb begin
    cmdWord               = '0;
    cmdWord[BIT_RX_EN]    = rxEnQ;
    cmdWord[BIT_ABORT_RX] = abortQ[0];
    cmdWord[BIT_ABORT_TX] = abortQ[1];
  end
endmodule

// File: rtl/dma_cmd_dpath.sv
module dma_cmd_dpath
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NUM_Q = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              frameOnly,
  input  logic [NUM_Q-1:0]  descClose,
  input  logic [NUM_Q-1:0]  descIntEn,
  input  logic [NUM_Q-1:0]  descLast,
  input  logic [NUM_Q-1:0]  rxResErr,
  input  logic              txUnderrun,
  input  logic              smiDone,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] IMPL = implMask(NUM_Q);
  localparam int unsigned SUM_W = SUM_HI - SUM_LO + 1;

  logic [NUM_Q-1:0]  retHit;
  logic [DATA_W-1:0] evVec;
  logic [DATA_W-1:0] causeQ, causeD;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] pending;
  logic [SUM_W-1:0]  sumSlice;
  logic              summary;
  logic              irqQ;

  // per-queue buffer-return qualification
  for (genvar q = 0; q < NUM_Q; q++) begin : g_ret
    assign retHit[q] = descClose[q] & descIntEn[q] & (~frameOnly | descLast[q]);
  end

  always_comb begin
    evVec                     = '0;
    evVec[BIT_ANY_RET]        = |retHit;
    evVec[RET_LSB +: NUM_Q]   = retHit;
    evVec[ERR_LSB +: NUM_Q]   = rxResErr;
    evVec[BIT_TX_UNDER]       = txUnderrun;
    evVec[BIT_SMI_DONE]       = smiDone;
  end

  // write-0-to-clear, events override the clear
  always_comb begin
    causeD = strobe.wrCause ? (causeQ & wrData) : causeQ;
    causeD = (causeD | evVec) & IMPL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
      irqQ   <= 1'b0;
    end else begin
      causeQ <= causeD;
      if (strobe.wrMask) maskQ <= wrData & IMPL;
      irqQ <= summary;
    end
  end

  assign pending  = causeQ & maskQ;
  assign sumSlice = pending[SUM_HI:SUM_LO];
  assign summary  = |sumSlice;
  assign irqOut   = irqQ;

  always_comb begin
    unique case (strobe.rdSel)
      REG_CMD:   rdData = cmdWord;
      REG_CAUSE: rdData = {summary, causeQ[BIT_SUMMARY-1:0]};
      REG_MASK:  rdData = maskQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_cmd_unit.sv
module dma_cmd_unit
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NUM_Q = 4   // receive queues, at most MAX_Q
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              rxIdle,
  input  logic              txIdle,
  output logic              rxEnable,
  output logic              abortRx,
  output logic              abortTx,
  input  logic              frameOnly,
  input  logic [NUM_Q-1:0]  descClose,
  input  logic [NUM_Q-1:0]  descIntEn,
  input  logic [NUM_Q-1:0]  descLast,
  input  logic [NUM_Q-1:0]  rxResErr,
  input  logic              txUnderrun,
  input  logic              smiDone,
  output logic              irqOut
);
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] cmdWord;

  dma_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .cmdBits  ({wrData[BIT_ABORT_TX], wrData[BIT_ABORT_RX], wrData[BIT_RX_EN]}),
    .rxIdle   (rxIdle),
    .txIdle   (txIdle),
    .strobe   (strobe),
    .rxEnable (rxEnable),
    .abortRx  (abortRx),
    .abortTx  (abortTx),
    .cmdWord  (cmdWord)
  );

  dma_cmd_dpath #(.NUM_Q(NUM_Q)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .cmdWord    (cmdWord),
    .frameOnly  (frameOnly),
    .descClose  (descClose),
    .descIntEn  (descIntEn),
    .descLast   (descLast),
    .rxResErr   (rxResErr),
    .txUnderrun (txUnderrun),
    .smiDone    (smiDone),
    .rdData     (rdData),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/dma_cmd_chk.sv
module dma_cmd_chk
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NUM_Q = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  addr,
  input logic [1:0]  abortBits,  // {write bit 31, write bit 15}
  input logic [31:0] rdData,
  input logic        rxIdle,
  input logic        txIdle,
  input logic        rxEnable,
  input logic        abortRx,
  input logic        abortTx,
  input logic        smiDone,
  input logic        irqOut
);
  localparam logic [31:0] IMPL = implMask(NUM_Q);

  logic reqRx, reqTx;
  assign reqRx = wrEn && (addr == 2'd0) && abortBits[0];
  assign reqTx = wrEn && (addr == 2'd0) && abortBits[1];

  AST_ABORT_STOPS_RX: assert property (@(posedge clk) disable iff (!rstN)
    reqRx |=> (!rxEnable && abortRx)); // R2
  AST_ABORT_RX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (abortRx && !rxIdle) |=> abortRx); // R3
  AST_ABORT_RX_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (abortRx && rxIdle && !reqRx) |=> !abortRx); // R3
  AST_ABORT_TX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (abortTx && !txIdle) |=> abortTx); // R3
  AST_ABORT_TX_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (abortTx && txIdle && !reqTx) |=> !abortTx); // R3
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    smiDone |=> (addr != 2'd1 || rdData[29])); // R6
  AST_MASK_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd2) |-> ((rdData & ~IMPL) == 32'd0)); // R7
  AST_IRQ_LAGS_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd1) |=> (irqOut == $past(rdData[31]))); // R9
  AST_CAUSE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd1) |-> ((rdData[30:0] & ~IMPL[30:0]) == 31'd0)); // R10
  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd3) |-> (rdData == 32'd0)); // R10
endmodule

bind dma_cmd_unit dma_cmd_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .abortBits ({wrData[31], wrData[15]}),
  .rdData    (rdData),
  .rxIdle    (rxIdle),
  .txIdle    (txIdle),
  .rxEnable  (rxEnable),
  .abortRx   (abortRx),
  .abortTx   (abortTx),
  .smiDone   (smiDone),
  .irqOut    (irqOut)
);

// File: tb/dma_cmd_unit_bench.sv
module dma_cmd_unit_bench;
  localparam int NQ = 4;
  localparam logic [31:0] IMPL = 32'h20FF2001;
  localparam logic [31:0] SUM_RANGE = 32'h7FFFFFF0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrEn, rxIdle, txIdle, frameOnly, txUnderrun, smiDone;
  logic rxEnable, abortRx, abortTx, irqOut;
  logic [1:0] addr;
  logic [31:0] wrData, rdData;
  logic [NQ-1:0] descClose, descIntEn, descLast, rxResErr;

  dma_cmd_unit #(.NUM_Q(NQ)) u_dma_cmd_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rxIdle(rxIdle), .txIdle(txIdle), .rxEnable(rxEnable),
    .abortRx(abortRx), .abortTx(abortTx), .frameOnly(frameOnly),
    .descClose(descClose), .descIntEn(descIntEn), .descLast(descLast),
    .rxResErr(rxResErr), .txUnderrun(txUnderrun), .smiDone(smiDone),
    .irqOut(irqOut)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] expCause = '0;
  logic [31:0] rd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic pulse(input logic [NQ-1:0] cl, input logic [NQ-1:0] ie,
                       input logic [NQ-1:0] la, input logic [NQ-1:0] er,
                       input logic un, input logic sm);
    logic [NQ-1:0] hit;
    @(negedge clk);
    descClose = cl; descIntEn = ie; descLast = la; rxResErr = er;
    txUnderrun = un; smiDone = sm;
    @(negedge clk);
    descClose = '0; descIntEn = '0; descLast = '0; rxResErr = '0;
    txUnderrun = 1'b0; smiDone = 1'b0;
    hit = cl & ie & (frameOnly ? la : {NQ{1'b1}});
    expCause = expCause | (32'(sm) << 29) | (32'(un) << 13) | (32'(er) << 20)
             | (32'(hit) << 16) | 32'(|hit);
  endtask

  function automatic logic [31:0] causeView(input logic [31:0] c, input logic [31:0] m);
    return {|(c & m & SUM_RANGE), c[30:0]};
  endfunction

  task automatic clearCause();
    regWrite(2'd1, 32'd0);
    expCause = '0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; rxIdle = 1'b0; txIdle = 1'b0;
    frameOnly = 1'b0; descClose = '0; descIntEn = '0; descLast = '0; rxResErr = '0;
    txUnderrun = 1'b0; smiDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd); check($sformatf("R1 addr %0d", a), rd, 32'd0);
    end
    check("R1 outputs", {28'd0, rxEnable, abortRx, abortTx, irqOut}, 32'd0);

    // R2 receive enable
    regWrite(2'd0, 32'h0000_0080);
    check("R2 enable set", 32'(rxEnable), 32'd1);
    regWrite(2'd0, 32'h0000_0000);
    check("R2 write0 keeps enable", 32'(rxEnable), 32'd1);
    regWrite(2'd0, 32'h0000_8080);
    check("R2 abort beats enable", {30'd0, rxEnable, abortRx}, 32'd1);

    // R3 receive abort holds until idle
    repeat (5) @(negedge clk);
    regRead(2'd0, rd); check("R3 rx abort held", rd, 32'h0000_8000);
    rxIdle = 1'b1;
    @(negedge clk);
    check("R3 rx abort cleared", 32'(abortRx), 32'd0);
    regRead(2'd0, rd); check("R3 rx readback zero", rd, 32'd0);
    rxIdle = 1'b0;

    // R3 transmit abort, write 0 no effect
    regWrite(2'd0, 32'h8000_0000);
    regWrite(2'd0, 32'h0000_0000);
    repeat (3) @(negedge clk);
    regRead(2'd0, rd); check("R3 tx abort held", rd, 32'h8000_0000);
    txIdle = 1'b1;
    @(negedge clk);
    check("R3 tx abort cleared", 32'(abortTx), 32'd0);
    txIdle = 1'b0;
    // abort written while already idle: set for one cycle then gone
    rxIdle = 1'b1;
    regWrite(2'd0, 32'h0000_8000);
    check("R3 rx abort set when idle", 32'(abortRx), 32'd1);
    @(negedge clk);
    check("R3 rx abort drops after idle", 32'(abortRx), 32'd0);
    rxIdle = 1'b0;

    // R10 command reserved bits
    regWrite(2'd0, 32'h7FFF_7F7F);
    regRead(2'd0, rd); check("R10 cmd reserved", rd, 32'd0);

    // R7 mask storage
    regWrite(2'd2, 32'hFFFF_FFFF);
    regRead(2'd2, rd); check("R7 mask all ones", rd, IMPL);
    regWrite(2'd2, 32'h0000_0000);
    regRead(2'd2, rd); check("R7 mask zero", rd, 32'd0);

    // R10 cause not settable by write, address 3 zero
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, rd); check("R10 cause write ones", rd, 32'd0);
    regRead(2'd3, rd); check("R10 addr3", rd, 32'd0);

    // R4 event positions
    for (int q = 0; q < NQ; q++) begin
      pulse('0, '0, '0, NQ'(1 << q), 1'b0, 1'b0);
      regRead(2'd1, rd); check($sformatf("R4 res err q%0d", q), rd, expCause);
      clearCause();
    end
    pulse('0, '0, '0, '0, 1'b1, 1'b0);
    regRead(2'd1, rd); check("R4 underrun", rd, 32'h0000_2000);
    clearCause();
    pulse('0, '0, '0, '0, 1'b0, 1'b1);
    regRead(2'd1, rd); check("R4 smi done", rd, 32'h2000_0000);
    clearCause();

    // R5 descriptor qualification sweep
    for (int fo = 0; fo < 2; fo++) begin
      frameOnly = fo[0];
      for (int q = 0; q < NQ; q++) begin
        for (int c = 0; c < 4; c++) begin
          pulse(NQ'(1 << q), c[0] ? NQ'(1 << q) : '0, c[1] ? NQ'(1 << q) : '0,
                '0, 1'b0, 1'b0);
          regRead(2'd1, rd);
          check($sformatf("R5 fo%0d q%0d ie%0d last%0d", fo, q, c[0], c[1]), rd, expCause);
          clearCause();
        end
      end
    end
    frameOnly = 1'b0;

    // R6 clear semantics
    pulse('0, '0, '0, 4'b0101, 1'b1, 1'b0);
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, rd); check("R6 write ones keep", rd, expCause);
    regWrite(2'd1, ~32'h0010_0000);
    expCause = expCause & ~32'h0010_0000;
    regRead(2'd1, rd); check("R6 selective clear", rd, expCause);
    @(negedge clk); addr = 2'd1; wrData = 32'd0; wrEn = 1'b1; smiDone = 1'b1;
    @(negedge clk); wrEn = 1'b0; smiDone = 1'b0;
    expCause = 32'h2000_0000;
    regRead(2'd1, rd); check("R6 event beats clear", rd, expCause);
    clearCause();

    // R8 / R9 summary and interrupt sweep, one mask bit at a time
    for (int b = 0; b < 32; b++) begin
      if (IMPL[b]) begin
        logic [31:0] m;
        logic s;
        m = 32'd1 << b;
        regWrite(2'd2, m);
        @(negedge clk);
        if (b == 0 || (b >= 16 && b < 20))
          pulse(NQ'(1 << (b >= 16 ? b - 16 : 0)), {NQ{1'b1}}, '0, '0, 1'b0, 1'b0);
        else if (b >= 20 && b < 24)
          pulse('0, '0, '0, NQ'(1 << (b - 20)), 1'b0, 1'b0);
        else if (b == 13)
          pulse('0, '0, '0, '0, 1'b1, 1'b0);
        else
          pulse('0, '0, '0, '0, 1'b0, 1'b1);
        s = |(expCause & m & SUM_RANGE);
        regRead(2'd1, rd); check($sformatf("R8 summary bit %0d", b), rd, causeView(expCause, m));
        check($sformatf("R9 irq not yet bit %0d", b), 32'(irqOut), 32'd0);
        @(negedge clk);
        check($sformatf("R9 irq bit %0d", b), 32'(irqOut), 32'(s));
        clearCause();
        check($sformatf("R9 irq falls bit %0d", b), 32'(irqOut), 32'd0);
      end
    end

    // R8 all mask bits, only bit 0 pending -> no summary
    regWrite(2'd2, 32'hFFFF_FFFF);
    pulse(4'b0001, 4'b0001, '0, '0, 1'b0, 1'b0);
    regWrite(2'd2, 32'h0000_0001);
    regRead(2'd1, rd); check("R8 bit0 excluded", rd, causeView(expCause, 32'h0000_0001));
    clearCause();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule